// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Idle Parking

This block decides which of N masters owns a shared 64-bit bus. The masters include the return paths of targets that send split-read data back to their requesters. Ownership rotates round-robin. A master keeps the bus for a whole transaction, which is one command plus its data octets, and gives it up by dropping its request line.

When nobody requests the bus, the block selects its own built-in parking device. That device drives every bus field to a safe value, so that no line floats:
- the command lines carry the park encoding;
- the byte enables, the target number and the reject lines are forced to fixed values;
- the address/data lines repeat the last value the previous owner drove, which avoids needless toggling.

While the bus is owned, the parking device drives zeros, so its outputs can be OR-ed onto the bus next to the owner's outputs.

A second, smaller arbiter serves a local bus. On that bus, a request that arrives from the global bus beats any local request made in the same cycle. Local requesters share the remaining slots round-robin among themselves.

Top module: `bus_arbiter_idle`

## Requirements
- R1: After synchronous reset, `mst_gnt` and `lb_loc_gnt` are all zero, `lb_gbl_gnt` is 0, `idle_sel` is 1, `idle_ad` is zero, `idle_dev` is all ones and `idle_cmd` is the park encoding 3'b111.
- R2: `mst_gnt` is at most one-hot. A bit is set only for a master whose request was high at the previous clock edge. A request sampled at an edge shows up on `mst_gnt` right after that edge.
- R3: While the owning master keeps its request high, its grant stays and requests from other masters have no effect.
- R4: When the owner drops its request, the grant passes at the next edge to the next requester in round-robin order, with no idle cycle between owners, or to nobody if no master requests.
- R5: A new grant goes to the first requesting master found by searching upward from the index just after the most recently granted master, wrapping from N-1 to 0. After reset the search starts at index 0.
- R6: `idle_sel` is 1 exactly when `mst_gnt` is all zero.
- R7: While `idle_sel` is 1, the parking outputs are fixed:
  - `idle_cmd` is 3'b111;
  - `idle_be` is all zero (enables are active-high);
  - `idle_dev` is all ones;
  - `idle_crj` is all zero.
- R8: While `idle_sel` is 1, `idle_ad` equals the `bus_ad_in` value present in the last cycle in which a grant was active, or zero if no grant has occurred since reset.
- R9: While `idle_sel` is 0, `idle_cmd`, `idle_ad` and `idle_dev` are zero.
- R10: On the local bus, when no local owner holds the bus, `lb_gbl_req` wins over any simultaneous `lb_loc_req`, and `lb_gbl_gnt` rises after that edge.
- R11: On the local bus, a local owner that still requests is not preempted by `lb_gbl_req`. When it releases, a waiting global request wins over waiting local requests.
- R12: Local requesters are granted round-robin among themselves, searching from the index after the last granted local requester. They hold the grant until they drop their request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_req | input | N_MST | Bus request, one bit per master |
| mst_gnt | output | N_MST | Registered one-hot bus grant |
| idle_sel | output | 1 | Parking device selected (no master owns the bus) |
| bus_ad_in | input | AD_W | Address/data value currently on the bus |
| idle_cmd | output | CMD_W | Parking device command lines |
| idle_be | output | BE_W | Parking device byte enables |
| idle_ad | output | AD_W | Parking device address/data lines |
| idle_dev | output | DEV_W | Parking device target number |
| idle_crj | output | CRJ_W | Parking device command-reject lines |
| lb_gbl_req | input | 1 | Local bus request from the global bus side |
| lb_loc_req | input | N_LOC | Local bus requests from local requesters |
| lb_gbl_gnt | output | 1 | Local bus grant to the global side |
| lb_loc_gnt | output | N_LOC | Local bus grants to local requesters |

## Verification
The bench sweeps the rotation pointer through every position, including a wrap where the only requester sits just below the pointer. An arbiter that searched from the last winner itself, or always from index 0, would grant the wrong master there. It checks that a held grant survives competing requests and that a handover happens in a single edge; a design that re-arbitrated every cycle or inserted an idle gap would be caught. The parked address/data value is tracked across owner-to-idle transitions and across long idle stretches, which exposes a design that parks zeros or keeps sampling the bus while parked. On the local bus, the bench creates simultaneous global and local requests, a global request against a holding local owner, and a release with both kinds waiting, so that a fixed-priority or preempting design fails.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned AD_W_DEF  = 64;
  localparam int unsigned CMD_W_DEF = 3;
  localparam int unsigned BE_W_DEF  = 8;
  localparam int unsigned DEV_W_DEF = 16;
  localparam int unsigned CRJ_W_DEF = 2;
  // Command encoding driven while the bus is parked
  localparam logic [CMD_W_DEF-1:0] CMD_PARK = 3'b111;
endpackage

// File: rtl/rr_core.sv
module rr_core #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         allow,
  output logic [N-1:0] gnt,
  output logic [N-1:0] gnt_nxt
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [N-1:0]  gnt_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick_idx;
  logic          pick_vld;
  logic          held;

  assign held = |(gnt_q & req);

  // search upward from the pointer, wrapping; lowest distance wins
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(ptr_q) + k) % N]) begin
        pick_vld = 1'b1;
        pick_idx = IW'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_comb begin
    if (held)                      gnt_nxt = gnt_q;
    else if (allow && pick_vld)    gnt_nxt = N'(1) << pick_idx;
    else                           gnt_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
      ptr_q <= '0;
    end else begin
      gnt_q <= gnt_nxt;
      if (!held && allow && pick_vld)
        ptr_q <= (pick_idx == LAST) ? '0 : pick_idx + 1'b1;
    end
  end

  assign gnt = gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)); // R2
  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    (|gnt_q) |-> (|(gnt_q & $past(req)))); // R2
  AST_OWNER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (|(gnt_q & req)) |=> (gnt_q == $past(gnt_q))); // R3
  AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ((|gnt_q) && !(|(gnt_q & req))) |=> ((gnt_q & $past(gnt_q)) == '0)); // R4
endmodule

// File: rtl/idle_park.sv
module idle_park #(
  parameter int unsigned AD_W  = arb_pkg::AD_W_DEF,
  parameter int unsigned CMD_W = arb_pkg::CMD_W_DEF,
  parameter int unsigned BE_W  = arb_pkg::BE_W_DEF,
  parameter int unsigned DEV_W = arb_pkg::DEV_W_DEF,
  parameter int unsigned CRJ_W = arb_pkg::CRJ_W_DEF,
  parameter logic [CMD_W-1:0] PARK_CMD = arb_pkg::CMD_PARK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_nxt,
  input  logic [AD_W-1:0]  bus_ad,
  output logic             idle_sel,
  output logic [CMD_W-1:0] cmd,
  output logic [BE_W-1:0]  be,
  output logic [AD_W-1:0]  ad,
  output logic [DEV_W-1:0] dev,
  output logic [CRJ_W-1:0] crj
);
  logic             idle_q;
  logic [CMD_W-1:0] cmd_q;
  logic [AD_W-1:0]  ad_q;
  logic [DEV_W-1:0] dev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b1;
      cmd_q  <= PARK_CMD;
      ad_q   <= '0;
      dev_q  <= '1;
    end else begin
      idle_q <= idle_nxt;
      cmd_q  <= idle_nxt ? PARK_CMD : '0;
      dev_q  <= idle_nxt ? '1 : '0;
      // entering idle: take the owner's last value; staying idle: hold
      if (!idle_nxt)   ad_q <= '0;
      else if (!idle_q) ad_q <= bus_ad;
    end
  end

  assign idle_sel = idle_q;
  assign cmd      = cmd_q;
  assign ad       = ad_q;
  assign dev      = dev_q;
  assign be       = '0;
  assign crj      = '0;

  AST_AD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!idle_q && idle_nxt) |=> (ad_q == $past(bus_ad))); // R8
  AST_AD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (idle_q && $past(idle_q)) |-> $stable(ad_q)); // R8
  AST_PARK_OFF: assert property (@(posedge clk) disable iff (rst)
    !idle_q |-> (ad_q == '0 && dev_q == '0)); // R9
endmodule

// File: rtl/local_arb.sv
module local_arb #(
  parameter int unsigned N_LOC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gbl_req,
  input  logic [N_LOC-1:0] loc_req,
  output logic             gbl_gnt,
  output logic [N_LOC-1:0] loc_gnt
);
  logic [N_LOC-1:0] loc_nxt;
  logic             g_q;

  // local requesters may only start when the global side is not asking
  rr_core #(.N(N_LOC)) u_loc_rr (
    .clk     (clk),
    .rst     (rst),
    .req     (loc_req),
    .allow   (~gbl_req),
    .gnt     (loc_gnt),
    .gnt_nxt (loc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) g_q <= 1'b0;
    else     g_q <= gbl_req & ~(|loc_nxt);
  end

  assign gbl_gnt = g_q;

  AST_LB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(g_q && (|loc_gnt))); // R10
  AST_GBL_WINS: assert property (@(posedge clk) disable iff (rst)
    (gbl_req && !(|(loc_gnt & loc_req))) |=> g_q); // R10
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (|(loc_gnt & loc_req)) |=> !g_q); // R11
endmodule

// File: rtl/bus_arbiter_idle.sv
module bus_arbiter_idle #(
  parameter int unsigned N_MST = 4,
  parameter int unsigned N_LOC = 2,
  parameter int unsigned AD_W  = arb_pkg::AD_W_DEF,
  parameter int unsigned CMD_W = arb_pkg::CMD_W_DEF,
  parameter int unsigned BE_W  = arb_pkg::BE_W_DEF,
  parameter int unsigned DEV_W = arb_pkg::DEV_W_DEF,
  parameter int unsigned CRJ_W = arb_pkg::CRJ_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MST-1:0] mst_req,
  output logic [N_MST-1:0] mst_gnt,
  output logic             idle_sel,
  input  logic [AD_W-1:0]  bus_ad_in,
  output logic [CMD_W-1:0] idle_cmd,
  output logic [BE_W-1:0]  idle_be,
  output logic [AD_W-1:0]  idle_ad,
  output logic [DEV_W-1:0] idle_dev,
  output logic [CRJ_W-1:0] idle_crj,
  input  logic             lb_gbl_req,
  input  logic [N_LOC-1:0] lb_loc_req,
  output logic             lb_gbl_gnt,
  output logic [N_LOC-1:0] lb_loc_gnt
);
  logic [N_MST-1:0] gnt_nxt;

  rr_core #(.N(N_MST)) u_main_rr (
    .clk     (clk),
    .rst     (rst),
    .req     (mst_req),
    .allow   (1'b1),
    .gnt     (mst_gnt),
    .gnt_nxt (gnt_nxt)
  );

  idle_park #(
    .AD_W(AD_W), .CMD_W(CMD_W), .BE_W(BE_W), .DEV_W(DEV_W), .CRJ_W(CRJ_W),
    .PARK_CMD(CMD_W'(arb_pkg::CMD_PARK))
  ) u_park (
    .clk      (clk),
    .rst      (rst),
    .idle_nxt (~(|gnt_nxt)),
    .bus_ad   (bus_ad_in),
    .idle_sel (idle_sel),
    .cmd      (idle_cmd),
    .be       (idle_be),
    .ad       (idle_ad),
    .dev      (idle_dev),
    .crj      (idle_crj)
  );

  local_arb #(.N_LOC(N_LOC)) u_local (
    .clk     (clk),
    .rst     (rst),
    .gbl_req (lb_gbl_req),
    .loc_req (lb_loc_req),
    .gbl_gnt (lb_gbl_gnt),
    .loc_gnt (lb_loc_gnt)
  );

  AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    idle_sel == ($countones(mst_gnt) == 0)); // R6
  AST_PARK_FIELDS: assert property (@(posedge clk) disable iff (rst)
    idle_sel |-> (idle_dev == '1 && idle_crj == '0 && idle_be == '0)); // R7
endmodule

// File: tb/bus_arbiter_idle_tb_top.sv
`timescale 1ns/100ps
module bus_arbiter_idle_tb_top;
  localparam int NM = 4;
  localparam int NL = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NM-1:0] mst_req = '0;
  logic [NM-1:0] mst_gnt;
  logic          idle_sel;
  logic [63:0]   bus_ad_in = '0;
  logic [2:0]    idle_cmd;
  logic [7:0]    idle_be;
  logic [63:0]   idle_ad;
  logic [15:0]   idle_dev;
  logic [1:0]    idle_crj;
  logic          lb_gbl_req = 1'b0;
  logic [NL-1:0] lb_loc_req = '0;
  logic          lb_gbl_gnt;
  logic [NL-1:0] lb_loc_gnt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bus_arbiter_idle #(.N_MST(NM), .N_LOC(NL)) dut_i (
    .clk(clk), .rst(rst), .mst_req(mst_req), .mst_gnt(mst_gnt),
    .idle_sel(idle_sel), .bus_ad_in(bus_ad_in), .idle_cmd(idle_cmd),
    .idle_be(idle_be), .idle_ad(idle_ad), .idle_dev(idle_dev),
    .idle_crj(idle_crj), .lb_gbl_req(lb_gbl_req), .lb_loc_req(lb_loc_req),
    .lb_gbl_gnt(lb_gbl_gnt), .lb_loc_gnt(lb_loc_gnt)
  );

  // {req, expected grant}; pointer starts at 0 after reset
  localparam logic [7:0] VEC [0:14] = '{
    8'b0000_0000, 8'b0110_0010, 8'b0110_0010, 8'b0100_0100, 8'b1101_0100,
    8'b1001_1000, 8'b0001_0001, 8'b1111_0001, 8'b1110_0010, 8'b1101_0100,
    8'b1011_1000, 8'b0111_0001, 8'b0000_0000, 8'b0001_0001, 8'b0000_0000
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk_park(input string tag, input logic exp_idle, input logic [63:0] exp_ad);
    chk({tag, " idle_sel R6"}, 64'(idle_sel), 64'(exp_idle));
    chk({tag, " idle_ad R8/R9"}, idle_ad, exp_ad);
    if (exp_idle) begin
      chk({tag, " cmd R7"}, 64'(idle_cmd), 64'h7);
      chk({tag, " be R7"}, 64'(idle_be), 64'h0);
      chk({tag, " dev R7"}, 64'(idle_dev), 64'hFFFF);
      chk({tag, " crj R7"}, 64'(idle_crj), 64'h0);
    end else begin
      chk({tag, " cmd R9"}, 64'(idle_cmd), 64'h0);
      chk({tag, " dev R9"}, 64'(idle_dev), 64'h0);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [63:0] exp_ad;
    logic        prev_idle;
    tick(); tick();
    // R1 reset state
    chk("R1 mst_gnt", 64'(mst_gnt), 64'h0);
    chk("R1 loc_gnt", 64'(lb_loc_gnt), 64'h0);
    chk("R1 gbl_gnt", 64'(lb_gbl_gnt), 64'h0);
    chk_park("R1", 1'b1, 64'h0);
    rst = 1'b0;

    // R2..R5 vector walk with R6..R9 parking checks
    exp_ad = '0;
    prev_idle = 1'b1;
    for (int i = 0; i < 15; i++) begin
      logic [3:0] eg;
      logic       eidle;
      mst_req   = VEC[i][7:4];
      bus_ad_in = 64'hA5A5_0000_0000_1000 + 64'(i);
      eg        = VEC[i][3:0];
      eidle     = (eg == 4'b0);
      if (!eidle)         exp_ad = '0;
      else if (!prev_idle) exp_ad = bus_ad_in;
      tick();
      chk($sformatf("R2/R3/R4/R5 step %0d mst_gnt", i), 64'(mst_gnt), 64'(eg));
      chk_park($sformatf("step %0d", i), eidle, exp_ad);
      prev_idle = eidle;
    end

    // R8 long idle stretch: parked value persists while bus_ad_in moves
    bus_ad_in = 64'hDEAD_BEEF_0000_0001;
    tick(); tick();
    chk("R8 hold over idle", idle_ad, exp_ad);

    // R10 simultaneous global and local requests on a free local bus
    lb_gbl_req = 1'b1; lb_loc_req = 2'b11;
    tick();
    chk("R10 gbl wins", 64'(lb_gbl_gnt), 64'h1);
    chk("R10 locals blocked", 64'(lb_loc_gnt), 64'h0);
    // R12 global leaves, locals take turns from pointer 0
    lb_gbl_req = 1'b0;
    tick();
    chk("R12 loc0 first", 64'(lb_loc_gnt), 64'h1);
    chk("R12 gbl off", 64'(lb_gbl_gnt), 64'h0);
    // R11 holding local owner is not preempted
    lb_gbl_req = 1'b1;
    tick();
    chk("R11 no preempt loc", 64'(lb_loc_gnt), 64'h1);
    chk("R11 no preempt gbl", 64'(lb_gbl_gnt), 64'h0);
    // R11 on release, waiting global beats waiting local
    lb_loc_req = 2'b10;
    tick();
    chk("R11 gbl after release", 64'(lb_gbl_gnt), 64'h1);
    chk("R11 loc1 waits", 64'(lb_loc_gnt), 64'h0);
    // R12 global leaves, both locals wait: pointer is past loc0
    lb_gbl_req = 1'b0; lb_loc_req = 2'b11;
    tick();
    chk("R12 loc1 next", 64'(lb_loc_gnt), 64'h2);
    lb_loc_req = 2'b00;
    tick();
    chk("R12 local release", 64'(lb_loc_gnt), 64'h0);

    // R1 reset during ownership
    mst_req = 4'b0100;
    bus_ad_in = 64'h1234;
    tick();
    chk("R5 grant before reset", 64'(mst_gnt), 64'h4);
    rst = 1'b1;
    tick();
    chk("R1 mid reset gnt", 64'(mst_gnt), 64'h0);
    chk_park("R1 mid reset", 1'b1, 64'h0);
    rst = 1'b0;
    mst_req = 4'b1111;
    tick();
    chk("R5 pointer cleared by reset", 64'(mst_gnt), 64'h1);
    mst_req = '0;
    tick();
    report();
  end
endmodule